// File: doc/BRIEF.md
# Coherent Reply Ordering Gate

This block sits inside a system coherence controller, between the queue of processor requests (coherent reads and writebacks) and the logic that issues system replies to the processor. A system reply starts the data transfer and hands ownership of the line to the processor. The processor owns the line from the cycle after it receives that reply. The gate records every snoop the system sends to the processor, keyed by cache index. It keeps each snoop open until the processor's snoop response for that index comes back.

While a snoop is open, no system reply for the same index may leave the gate. The processor request can arrive before or after the snoop; the gate defers it in both cases. A deferred reply at the head of the queue moves into a one-entry park slot. Replies for other indexes then keep flowing behind it in queue order. A small ownership model registers each issued reply, so the surrounding logic and a bench can see when ownership passes to the processor.

Back-pressure rules:
- Snoop requests and processor requests are valid/ready inputs.
- `snp_req_ready` is low while the tracker is full, and also while the offered index equals the index currently presented on `srp_idx` with `srp_valid` high.
- `prq_ready` is low while the request queue is full.
- The system reply output is valid/ready. Once `srp_valid` is high, it and `srp_idx` stay unchanged until `srp_ready` is seen.
- The snoop response input has no ready signal and is always taken.

Top module: `coh_reply_gate`

## Requirements
- R1: After reset, `snp_req_ready` and `prq_ready` are 1, and `srp_valid` and `own_valid` are 0.
- R2: The tracker holds at most NSNP (default 4) open snoops. With NSNP open, `snp_req_ready` is 0.
- R3: No system reply handshake (`srp_valid && srp_ready`) occurs while an open snoop has the same index as `srp_idx`.
- R4: A processor request is deferred whether it arrives in the same cycle as the snoop to its index or after that snoop. It issues only after the snoop response for that index.
- R5: A snoop response frees the matching entry at the end of the cycle in which it is seen. A reply held for that index is presented no earlier than the following cycle, and the freed slot accepts a new snoop from the following cycle.
- R6: A blocked reply is parked in a one-entry slot. A queued reply for an unblocked index may issue while the parked one waits. When both the parked reply and the queue head are unblocked, the parked reply issues first.
- R7: While the park slot holds a blocked reply and the queue head is also blocked, `srp_valid` is 0.
- R8: `own_valid` is 1 in the cycle after a reply handshake, with `own_idx` equal to the index handed over, and is 0 otherwise.
- R9: A snoop response whose index matches no open snoop changes no tracker state.
- R10: While `srp_valid` is 1 and `srp_ready` is 0, `srp_valid` and `srp_idx` stay unchanged into the next cycle. A snoop request for the presented index is stalled.
- R11: The processor request queue holds QDEPTH (default 4) entries. When it is full, `prq_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_req_valid | input | 1 | System snoop request to the processor is offered |
| snp_req_ready | output | 1 | Snoop request may be accepted this cycle |
| snp_req_idx | input | IDXW | Cache index of the snoop |
| snp_rsp_valid | input | 1 | Processor snoop response seen |
| snp_rsp_idx | input | IDXW | Cache index the processor answered |
| prq_valid | input | 1 | Processor coherent read or writeback request offered |
| prq_ready | output | 1 | Request queue can take the request |
| prq_idx | input | IDXW | Cache index of the processor request |
| srp_valid | output | 1 | System reply presented |
| srp_ready | input | 1 | Reply issue logic takes the reply |
| srp_idx | output | IDXW | Cache index of the presented reply |
| own_valid | output | 1 | Processor takes ownership this cycle |
| own_idx | output | IDXW | Index whose ownership passes |

## Verification
Two things can coincide in one cycle. A snoop response can free an entry in the same cycle that the blocked queue head is moved into the park slot. A parked reply can become unblocked in the same cycle that an unrelated queue head is also ready to go. The bench sets up both collisions with directed cycle-by-cycle stimulus. It expects the parked index to be presented first, on the cycle after the response and not before. It also checks that the request that arrives in the same cycle as its snoop stays held until the response.

// File: rtl/crg_pkg.sv
package crg_pkg;
  // where the presented reply comes from
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PARK = 2'd1,
    SRC_HEAD = 2'd2
  } src_e;
endpackage

// File: rtl/crg_snoop_tracker.sv
module crg_snoop_tracker #(
  parameter int NSNP = 4,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_v,
  input  logic [IDXW-1:0] alloc_idx,
  input  logic            free_v,
  input  logic [IDXW-1:0] free_idx,
  input  logic [IDXW-1:0] lk_a_idx,
  output logic            lk_a_hit,
  input  logic [IDXW-1:0] lk_b_idx,
  output logic            lk_b_hit,
  output logic            full,
  output logic [NSNP-1:0] ent_v,
  output logic [IDXW-1:0] ent_idx [NSNP]
);
  logic [NSNP-1:0] empty_oh, rel_oh, rel_hit, a_hit, b_hit;
  logic            got_empty, got_rel;

  // per-entry comparators, all in parallel
  for (genvar g = 0; g < NSNP; g++) begin : g_cmp
    assign rel_hit[g] = ent_v[g] && (ent_idx[g] == free_idx);
    assign a_hit[g]   = ent_v[g] && (ent_idx[g] == lk_a_idx);
    assign b_hit[g]   = ent_v[g] && (ent_idx[g] == lk_b_idx);
  end

  // lowest free slot and lowest matching slot
  always_comb begin
    empty_oh  = '0;
    rel_oh    = '0;
    got_empty = 1'b0;
    got_rel   = 1'b0;
    for (int i = 0; i < NSNP; i++) begin
      if (!ent_v[i] && !got_empty) begin
        empty_oh[i] = 1'b1;
        got_empty   = 1'b1;
      end
      if (rel_hit[i] && !got_rel) begin
        rel_oh[i] = 1'b1;
        got_rel   = 1'b1;
      end
    end
  end

  assign lk_a_hit = |a_hit;
  assign lk_b_hit = |b_hit;
  assign full     = &ent_v;

  for (genvar g = 0; g < NSNP; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[g]   <= 1'b0;
        ent_idx[g] <= '0;
      end else if (free_v && rel_oh[g]) begin
        ent_v[g] <= 1'b0;
      end else if (alloc_v && empty_oh[g]) begin
        ent_v[g]   <= 1'b1;
        ent_idx[g] <= alloc_idx;
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_v |-> !full);

  // R5
  free_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_v && got_rel && !alloc_v) |=> ($countones(ent_v) == $past($countones(ent_v)) - 1));

  // R9
  stray_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_v && !got_rel && !alloc_v) |=> $stable(ent_v));
endmodule

// File: rtl/crg_reply_fifo.sv
module crg_reply_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R11
  no_fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R11
  no_fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/crg_reply_select.sv
module crg_reply_select
  import crg_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_present,
  input  logic [IDXW-1:0] head_idx,
  input  logic            head_hit,
  input  logic            park_hit,
  output logic [IDXW-1:0] park_idx,
  output logic            pop,
  output logic            srp_valid,
  input  logic            srp_ready,
  output logic [IDXW-1:0] srp_idx
);
  logic park_v, park_ok, head_ok, park_load, stall_q;
  src_e src_now, stall_src_q;

  always_comb begin
    park_ok = park_v && !park_hit;
    head_ok = head_present && !head_hit;
    if (stall_q)      src_now = stall_src_q;
    else if (park_ok) src_now = SRC_PARK;
    else if (head_ok) src_now = SRC_HEAD;
    else              src_now = SRC_NONE;
  end

  assign park_load = (src_now == SRC_NONE) && !park_v && head_present && head_hit;
  assign srp_valid = (src_now != SRC_NONE);
  assign srp_idx   = (src_now == SRC_PARK) ? park_idx : head_idx;
  assign pop       = ((src_now == SRC_HEAD) && srp_ready) || park_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      park_v      <= 1'b0;
      park_idx    <= '0;
      stall_q     <= 1'b0;
      stall_src_q <= SRC_NONE;
    end else begin
      if (park_load) begin
        park_v   <= 1'b1;
        park_idx <= head_idx;
      end else if ((src_now == SRC_PARK) && srp_ready) begin
        park_v <= 1'b0;
      end
      stall_q     <= srp_valid && !srp_ready;
      stall_src_q <= src_now;
    end
  end

  // R10
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srp_valid && !srp_ready) |=> (srp_valid && $stable(srp_idx)));

  // R6
  park_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_v && !park_hit && !stall_q) |-> (srp_valid && srp_idx == park_idx));
endmodule

// File: rtl/crg_owner_model.sv
module crg_owner_model #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hand_v,
  input  logic [IDXW-1:0] hand_idx,
  output logic            own_valid,
  output logic [IDXW-1:0] own_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_valid <= 1'b0;
      own_idx   <= '0;
    end else begin
      own_valid <= hand_v;
      if (hand_v) own_idx <= hand_idx;
    end
  end

  // R8
  own_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_v |=> (own_valid && own_idx == $past(hand_idx)));
endmodule

// File: rtl/coh_reply_gate.sv
module coh_reply_gate #(
  parameter int NSNP   = 4,
  parameter int QDEPTH = 4,
  parameter int IDXW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snp_req_valid,
  output logic            snp_req_ready,
  input  logic [IDXW-1:0] snp_req_idx,
  input  logic            snp_rsp_valid,
  input  logic [IDXW-1:0] snp_rsp_idx,
  input  logic            prq_valid,
  output logic            prq_ready,
  input  logic [IDXW-1:0] prq_idx,
  output logic            srp_valid,
  input  logic            srp_ready,
  output logic [IDXW-1:0] srp_idx,
  output logic            own_valid,
  output logic [IDXW-1:0] own_idx
);
  logic            trk_full, head_hit, park_hit, q_empty, q_full, q_pop;
  logic [IDXW-1:0] head_idx, park_idx;
  logic [NSNP-1:0] ent_v;
  logic [IDXW-1:0] ent_idx [NSNP];
  logic            snp_fire, prq_fire, srp_fire;

  // a snoop may not open on the index being handed over right now
  assign snp_req_ready = !trk_full && !(srp_valid && (srp_idx == snp_req_idx));
  assign prq_ready     = !q_full;
  assign snp_fire      = snp_req_valid && snp_req_ready;
  assign prq_fire      = prq_valid && prq_ready;
  assign srp_fire      = srp_valid && srp_ready;

  crg_snoop_tracker #(.NSNP(NSNP), .IDXW(IDXW)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .alloc_v(snp_fire), .alloc_idx(snp_req_idx),
    .free_v(snp_rsp_valid), .free_idx(snp_rsp_idx),
    .lk_a_idx(park_idx), .lk_a_hit(park_hit),
    .lk_b_idx(head_idx), .lk_b_hit(head_hit),
    .full(trk_full), .ent_v(ent_v), .ent_idx(ent_idx)
  );

  crg_reply_fifo #(.DEPTH(QDEPTH), .W(IDXW)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(prq_fire), .push_data(prq_idx), .pop(q_pop),
    .head(head_idx), .empty(q_empty), .full(q_full)
  );

  crg_reply_select #(.IDXW(IDXW)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .head_present(!q_empty), .head_idx(head_idx), .head_hit(head_hit),
    .park_hit(park_hit), .park_idx(park_idx), .pop(q_pop),
    .srp_valid(srp_valid), .srp_ready(srp_ready), .srp_idx(srp_idx)
  );

  crg_owner_model #(.IDXW(IDXW)) u_own (
    .clk(clk), .rst_n(rst_n),
    .hand_v(srp_fire), .hand_idx(srp_idx),
    .own_valid(own_valid), .own_idx(own_idx)
  );

  // open-window monitor over the tracker contents
  logic window_clash;
  always_comb begin
    window_clash = 1'b0;
    for (int i = 0; i < NSNP; i++)
      if (ent_v[i] && ent_idx[i] == srp_idx) window_clash = 1'b1;
  end

  // R3
  no_conflict_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srp_fire |-> !window_clash);

  // R10
  snoop_vs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_fire && srp_valid) |-> (snp_req_idx != srp_idx));
endmodule

// File: tb/coh_reply_gate_tb.sv
module coh_reply_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       snp_req_valid = 1'b0, snp_req_ready;
  logic [7:0] snp_req_idx = '0;
  logic       snp_rsp_valid = 1'b0;
  logic [7:0] snp_rsp_idx = '0;
  logic       prq_valid = 1'b0, prq_ready;
  logic [7:0] prq_idx = '0;
  logic       srp_valid, srp_ready = 1'b1;
  logic [7:0] srp_idx;
  logic       own_valid;
  logic [7:0] own_idx;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coh_reply_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .snp_req_valid(snp_req_valid), .snp_req_ready(snp_req_ready), .snp_req_idx(snp_req_idx),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_idx(snp_rsp_idx),
    .prq_valid(prq_valid), .prq_ready(prq_ready), .prq_idx(prq_idx),
    .srp_valid(srp_valid), .srp_ready(srp_ready), .srp_idx(srp_idx),
    .own_valid(own_valid), .own_idx(own_idx)
  );

  typedef struct packed {
    logic sv; logic [7:0] si;
    logic pv; logic [7:0] pi;
    logic fv; logic [7:0] fi;
    logic ev; logic [7:0] ei;
    logic ov; logic [7:0] oi;
  } vec_t;

  // per cycle: snoop, request, snoop response, expected reply, expected owner
  localparam vec_t TBL [13] = '{
    '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 8'h00, 1'b1, 8'h22},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h11},
    '{1'b1, 8'h33, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h33}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wait for the falling edge and clear all stimulus
  task automatic tick();
    @(negedge clk);
    snp_req_valid = 1'b0;
    prq_valid     = 1'b0;
    snp_rsp_valid = 1'b0;
  endtask

  task automatic snoop(input logic [7:0] i);
    snp_req_valid = 1'b1; snp_req_idx = i;
  endtask
  task automatic req(input logic [7:0] i);
    prq_valid = 1'b1; prq_idx = i;
  endtask
  task automatic rsp(input logic [7:0] i);
    snp_rsp_valid = 1'b1; snp_rsp_idx = i;
  endtask

  task automatic expect_reply(input string tag, input logic v, input logic [7:0] i);
    check({tag, " srp_valid"}, 32'(srp_valid), 32'(v));
    if (v) check({tag, " srp_idx"}, 32'(srp_idx), 32'(i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 snp_req_ready", 32'(snp_req_ready), 32'd1);
    check("R1 prq_ready", 32'(prq_ready), 32'd1);
    check("R1 srp_valid", 32'(srp_valid), 32'd0);
    check("R1 own_valid", 32'(own_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table: R3, R4, R5 and R8 over both arrival orders
    for (int k = 0; k < 13; k++) begin
      tick();
      if (TBL[k].sv) snoop(TBL[k].si);
      if (TBL[k].pv) req(TBL[k].pi);
      if (TBL[k].fv) rsp(TBL[k].fi);
      #1;
      expect_reply($sformatf("R3 row %0d", k), TBL[k].ev, TBL[k].ei);
      check($sformatf("R8 row %0d own_valid", k), 32'(own_valid), 32'(TBL[k].ov));
      if (TBL[k].ov) check($sformatf("R8 row %0d own_idx", k), 32'(own_idx), 32'(TBL[k].oi));
    end

    // R2 fill the tracker, R9 stray response, R5 slot reuse
    for (int k = 1; k <= 4; k++) begin
      tick(); snoop(8'(k)); #1;
      check("R2 ready while not full", 32'(snp_req_ready), 32'd1);
    end
    tick(); snoop(8'h05); #1;
    check("R2 ready when full", 32'(snp_req_ready), 32'd0);
    tick(); rsp(8'h99);
    tick(); snoop(8'h05); #1;
    check("R9 stray response frees nothing", 32'(snp_req_ready), 32'd0);
    tick(); rsp(8'h02); #1;
    check("R5 freed slot not ready in response cycle", 32'(snp_req_ready), 32'd0);
    tick(); snoop(8'h05); #1;
    check("R5 freed slot ready next cycle", 32'(snp_req_ready), 32'd1);
    tick(); rsp(8'h01);
    tick(); rsp(8'h03);
    tick(); rsp(8'h04);
    tick(); rsp(8'h05);

    // R11 queue full, R10 hold under back-pressure, R8 back-to-back ownership
    srp_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick(); req(8'h40 + 8'(k)); #1;
      check("R11 prq_ready while not full", 32'(prq_ready), 32'd1);
    end
    tick(); req(8'h44); #1;
    check("R11 prq_ready when full", 32'(prq_ready), 32'd0);
    expect_reply("R10 offer under stall", 1'b1, 8'h40);
    tick(); snoop(8'h40); #1;
    check("R10 snoop on offered index stalled", 32'(snp_req_ready), 32'd0);
    expect_reply("R10 offer held", 1'b1, 8'h40);
    tick(); snoop(8'h50); #1;
    check("R10 snoop on other index taken", 32'(snp_req_ready), 32'd1);
    tick(); rsp(8'h50); srp_ready = 1'b1; #1;
    expect_reply("R10 offer still held", 1'b1, 8'h40);
    for (int k = 1; k < 4; k++) begin
      tick(); #1;
      expect_reply("R11 drain order", 1'b1, 8'h40 + 8'(k));
      check("R8 own_valid drain", 32'(own_valid), 32'd1);
      check("R8 own_idx drain", 32'(own_idx), 32'h40 + 32'(k - 1));
    end
    tick(); #1;
    expect_reply("R11 drained", 1'b0, 8'h00);
    check("R8 own_idx last", 32'(own_idx), 32'h43);
    tick(); #1;
    check("R8 own_valid idle", 32'(own_valid), 32'd0);

    // R7 both blocked, R6 bypass of parked reply
    tick(); snoop(8'h61);
    tick(); snoop(8'h62);
    tick(); req(8'h61); #1; expect_reply("R4 empty queue", 1'b0, 8'h00);
    tick(); req(8'h62); #1; expect_reply("R4 head blocked", 1'b0, 8'h00);
    tick(); #1; expect_reply("R7 park and head blocked", 1'b0, 8'h00);
    tick(); rsp(8'h62); #1; expect_reply("R7 still blocked in response cycle", 1'b0, 8'h00);
    tick(); #1; expect_reply("R6 bypass of parked reply", 1'b1, 8'h62);
    tick(); rsp(8'h61); #1; expect_reply("R6 parked waits", 1'b0, 8'h00);
    tick(); #1; expect_reply("R5 parked released next cycle", 1'b1, 8'h61);
    tick(); #1; expect_reply("R6 idle", 1'b0, 8'h00);

    // R6 parked reply wins over unblocked head; response coincides with park load
    tick(); snoop(8'h71);
    tick(); req(8'h71);
    tick(); req(8'h72); rsp(8'h71); #1;
    expect_reply("R5 held during response cycle", 1'b0, 8'h00);
    tick(); #1; expect_reply("R6 parked first", 1'b1, 8'h71);
    tick(); #1; expect_reply("R6 head after parked", 1'b1, 8'h72);
    tick(); #1; expect_reply("R6 empty", 1'b0, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule